// File: doc/BRIEF.md
# Indexed-Port Real-Time Clock with Periodic Interrupt

This block models a real-time clock peripheral reached through a two-port indirect bus. The bus has an index port and a data port. A write to the index port stores a 7-bit register number. Any later access to the data port reads or writes the register that number names. The index is shared by every bus master and stays in place until the next index write. A master that writes the index between another master's index write and data access therefore redirects that access.

Inside are seconds, minutes and hours counters, driven by a seconds tick. The tick is a cycle divider set by a parameter, which stands in for the real oscillator. A control register holds the periodic-interrupt enable. A status register reports a periodic event. The periodic generator fires at a fixed cycle interval. It raises a flag, and that flag stays up until the status register is read. Reading the status register is the only way to re-arm the interrupt. A read of any other register leaves the interrupt pending.

Top module: `rtc_indexed`

## Requirements
- R1: A write with `bus_port`=0 latches `bus_wdata[6:0]` as the index, and bit 7 is discarded. The index holds until the next index write. Every data access (`bus_port`=1) targets the latched index.
- R2: Seconds are at index 0x00, minutes at 0x02 and hours at 0x04, each readable and writable as a binary byte. Unused indices (for example 0x20) read 0x00.
- R3: After reset, the time registers are 0, the control register (index 0x0B) is 0x42, the status register (index 0x0C) reads 0x00, `irq` is low and the index is 0.
- R4: Seconds advance by one every `SEC_CYCLES` cycles. Writing the seconds register restarts that interval, so the next step comes exactly `SEC_CYCLES` cycles after the write.
- R5: Seconds wrap from 59 to 0 and carry into minutes. Minutes wrap from 59 to 0 and carry into hours. Hours wrap from 23 to 0.
- R6: Every `PER_CYCLES` cycles a periodic event sets the periodic flag, which is status bit 6. Status bit 7 reads as the periodic flag ANDed with control bit 6.
- R7: `irq` is high exactly while status bit 7 is set. It falls in the cycle after a data read of the status register.
- R8: Once the flag is set, further periodic events change nothing. Only a status read clears it, and a second status read right after that returns 0x00.
- R9: A data read of any register other than the status register does not clear the flag. This includes a read redirected by a foreign index write between the index write and the data read.
- R10: Data writes to the status register are ignored. The control register is fully writable. With control bit 6 at 0, `irq` stays low while the periodic flag still sets.
- R11: Read data appears on `bus_rdata` one cycle after the data read and holds until the next data read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_port | input | 1 | 0 = index port, 1 = data port |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| irq | output | 1 | Periodic interrupt level |

## Verification
The most telling fault is a flag that a wrong register clears, or one that is never cleared. It shows at `irq` in the cycle after the faulty access: `irq` drops after a redirected time read, or it stays high after a genuine status read. A corrupted index shows on the very next data read, which returns another register's value. Counter and carry faults show on the first read after one seconds interval.

// File: rtl/rtc_idx_pkg.sv
package rtc_idx_pkg;
  localparam logic [6:0] IDX_SEC  = 7'h00;
  localparam logic [6:0] IDX_MIN  = 7'h02;
  localparam logic [6:0] IDX_HR   = 7'h04;
  localparam logic [6:0] IDX_CTRL = 7'h0B;
  localparam logic [6:0] IDX_STAT = 7'h0C;

  localparam logic [7:0] CTRL_RESET = 8'h42;
  localparam int PIE_BIT  = 6;

  localparam logic [7:0] SEC_LAST = 8'd59;
  localparam logic [7:0] MIN_LAST = 8'd59;
  localparam logic [7:0] HR_LAST  = 8'd23;

  typedef enum logic [1:0] {
    FLD_NONE = 2'd0,
    FLD_SEC  = 2'd1,
    FLD_MIN  = 2'd2,
    FLD_HR   = 2'd3
  } time_fld_e;
endpackage

// File: rtl/rtc_divider.sv
module rtc_divider #(
  parameter int unsigned LIMIT = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic tick
);
  localparam int unsigned CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (restart)
      cnt_d = '0;
    else if (cnt_q == LAST)
      cnt_d = '0;
    else
      cnt_d = cnt_q + 1'b1;
  end

  assign tick = (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt_q == '0)); // R4
endmodule

// File: rtl/rtc_timekeeper.sv
module rtc_timekeeper
  import rtc_idx_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      tick,
  input  time_fld_e wr_fld,
  input  logic [7:0] wr_val,
  output logic [7:0] sec_o,
  output logic [7:0] min_o,
  output logic [7:0] hr_o
);
  logic [7:0] sec_q, min_q, hr_q;
  logic [7:0] sec_d, min_d, hr_d;

  always_comb begin
    sec_d = sec_q;
    min_d = min_q;
    hr_d  = hr_q;
    case (wr_fld)
      FLD_SEC: sec_d = wr_val;
      FLD_MIN: min_d = wr_val;
      FLD_HR:  hr_d  = wr_val;
      default: begin
        if (tick) begin
          if (sec_q >= SEC_LAST) begin
            sec_d = '0;
            if (min_q >= MIN_LAST) begin
              min_d = '0;
              hr_d  = (hr_q >= HR_LAST) ? 8'd0 : hr_q + 8'd1;
            end else begin
              min_d = min_q + 8'd1;
            end
          end else begin
            sec_d = sec_q + 8'd1;
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec_q <= '0;
      min_q <= '0;
      hr_q  <= '0;
    end else begin
      sec_q <= sec_d;
      min_q <= min_d;
      hr_q  <= hr_d;
    end
  end

  assign sec_o = sec_q;
  assign min_o = min_q;
  assign hr_o  = hr_q;

  AST_SEC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && wr_fld == FLD_NONE && sec_q == SEC_LAST) |=> (sec_q == 8'd0)); // R5
  AST_SEC_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && wr_fld == FLD_NONE) |=> $stable(sec_q)); // R4
endmodule

// File: rtl/rtc_periodic.sv
module rtc_periodic #(
  parameter int unsigned PER_CYCLES = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ack,
  output logic pend
);
  logic evt;
  logic pend_q, pend_d;

  rtc_divider #(.LIMIT(PER_CYCLES)) u_per_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (1'b0),
    .tick    (evt)
  );

  always_comb begin
    pend_d = pend_q;
    if (evt)
      pend_d = 1'b1;
    else if (ack)
      pend_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_d;
  end

  assign pend = pend_q;

  AST_FLAG_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend_q) |-> $past(evt)); // R6
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !ack) |=> pend_q); // R8
  AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !evt) |=> !pend_q); // R7
endmodule

// File: rtl/rtc_indexed.sv
module rtc_indexed
  import rtc_idx_pkg::*;
#(
  parameter int unsigned SEC_CYCLES = 1000,
  parameter int unsigned PER_CYCLES = 100
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_en,
  input  logic       bus_wr,
  input  logic       bus_port,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       irq
);
  logic [6:0] index_q, index_d;
  logic [7:0] ctrl_q, ctrl_d;
  logic [7:0] rdata_q, rdata_d;
  logic       idx_wr, data_wr, data_rd, stat_ack;
  logic       sec_tick, pend;
  time_fld_e  wr_fld;
  logic [7:0] sec_v, min_v, hr_v, stat_byte, rd_mux;

  assign idx_wr   = bus_en &  bus_wr & ~bus_port;
  assign data_wr  = bus_en &  bus_wr &  bus_port;
  assign data_rd  = bus_en & ~bus_wr &  bus_port;
  assign stat_ack = data_rd && (index_q == IDX_STAT);

  always_comb begin
    wr_fld = FLD_NONE;
    if (data_wr) begin
      case (index_q)
        IDX_SEC: wr_fld = FLD_SEC;
        IDX_MIN: wr_fld = FLD_MIN;
        IDX_HR:  wr_fld = FLD_HR;
        default: wr_fld = FLD_NONE;
      endcase
    end
  end

  rtc_divider #(.LIMIT(SEC_CYCLES)) u_sec_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (wr_fld == FLD_SEC),
    .tick    (sec_tick)
  );

  rtc_timekeeper u_time (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (sec_tick),
    .wr_fld (wr_fld),
    .wr_val (bus_wdata),
    .sec_o  (sec_v),
    .min_o  (min_v),
    .hr_o   (hr_v)
  );

  rtc_periodic #(.PER_CYCLES(PER_CYCLES)) u_per (
    .clk   (clk),
    .rst_n (rst_n),
    .ack   (stat_ack),
    .pend  (pend)
  );

  assign stat_byte = {pend & ctrl_q[PIE_BIT], pend, 6'b0};

  always_comb begin
    case (index_q)
      IDX_SEC:  rd_mux = sec_v;
      IDX_MIN:  rd_mux = min_v;
      IDX_HR:   rd_mux = hr_v;
      IDX_CTRL: rd_mux = ctrl_q;
      IDX_STAT: rd_mux = stat_byte;
      default:  rd_mux = 8'h00;
    endcase
  end

  always_comb begin
    index_d = idx_wr ? bus_wdata[6:0] : index_q;
    ctrl_d  = (data_wr && index_q == IDX_CTRL) ? bus_wdata : ctrl_q;
    rdata_d = data_rd ? rd_mux : rdata_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      index_q <= '0;
      ctrl_q  <= CTRL_RESET;
      rdata_q <= '0;
    end else begin
      index_q <= index_d;
      ctrl_q  <= ctrl_d;
      rdata_q <= rdata_d;
    end
  end

  assign bus_rdata = rdata_q;
  assign irq       = pend & ctrl_q[PIE_BIT];

  AST_INDEX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !idx_wr |=> $stable(index_q)); // R1
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !data_rd |=> $stable(bus_rdata)); // R11
  AST_FOREIGN_READ_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && data_rd && index_q != IDX_STAT && !(data_wr && index_q == IDX_CTRL)) |=> irq); // R9
  AST_CTRL_ONLY_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !data_wr |=> $stable(ctrl_q)); // R10
endmodule

// File: tb/rtc_indexed_tb.sv
module rtc_indexed_tb;
  localparam int unsigned SEC = 40;
  localparam int unsigned PER = 50;

  logic       clk, rst_n, bus_en, bus_wr, bus_port, irq;
  logic [7:0] bus_wdata, bus_rdata;
  int n_chk, n_fail, cyc;
  logic [7:0] v;

  rtc_indexed #(.SEC_CYCLES(SEC), .PER_CYCLES(PER)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_wr(bus_wr),
    .bus_port(bus_port), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      n_chk = n_chk + 1;
      n_fail = n_fail + 1;
      $display("FAIL watchdog: got %0d cycles expected fewer", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk = n_chk + 1;
    if (act !== exp) begin
      n_fail = n_fail + 1;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic access(input logic wr, input logic port, input logic [7:0] d);
    bus_en = 1'b1; bus_wr = wr; bus_port = port; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_en = 1'b0; bus_wr = 1'b0; bus_port = 1'b0; bus_wdata = 8'h00;
  endtask

  task automatic set_idx(input logic [7:0] i);
    access(1'b1, 1'b0, i);
  endtask

  task automatic rd_data(output logic [7:0] d);
    access(1'b0, 1'b1, 8'h00);
    d = bus_rdata;
  endtask

  task automatic wr_reg(input logic [7:0] i, input logic [7:0] d);
    set_idx(i);
    access(1'b1, 1'b1, d);
  endtask

  task automatic rd_reg(input logic [7:0] i, output logic [7:0] d);
    set_idx(i);
    rd_data(d);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_irq();
    logic [7:0] t;
    rd_reg(8'h0C, t);
    for (int k = 0; k < 3 * PER && !irq; k++) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R3 irq low", {7'b0, irq}, 8'h00);
    rd_data(v); chk("R3 index 0 selects seconds", v, 8'h00);
    rd_reg(8'h0B, v); chk("R3 control reset", v, 8'h42);
    rd_reg(8'h0C, v); chk("R3 status reset", v, 8'h00);
    rd_reg(8'h20, v); chk("R2 unused index", v, 8'h00);
    rd_reg(8'h8B, v); chk("R1 index bit7 dropped", v, 8'h42);
  endtask

  task automatic t_index_persist();
    wr_reg(8'h02, 8'h05);
    rd_data(v); chk("R1 reuse index read 1", v, 8'h05);
    rd_data(v); chk("R1 reuse index read 2", v, 8'h05);
    access(1'b1, 1'b1, 8'h07);
    rd_data(v); chk("R1 write without new index", v, 8'h07);
    rd_reg(8'h02, v); chk("R2 minutes readback", v, 8'h07);
  endtask

  task automatic t_seconds();
    wr_reg(8'h00, 8'd30);
    rd_data(v); chk("R4 seconds just written", v, 8'd30);
    idle(SEC);
    rd_data(v); chk("R4 one step after interval", v, 8'd31);
    rd_reg(8'h02, v); chk("R4 minutes unchanged", v, 8'h07);
  endtask

  task automatic t_rollover();
    wr_reg(8'h04, 8'd23);
    wr_reg(8'h02, 8'd59);
    wr_reg(8'h00, 8'd59);
    idle(SEC + 2);
    rd_reg(8'h00, v); chk("R5 seconds wrap", v, 8'd0);
    rd_reg(8'h02, v); chk("R5 minutes wrap", v, 8'd0);
    rd_reg(8'h04, v); chk("R5 hours wrap", v, 8'd0);
  endtask

  task automatic t_one_shot();
    wait_irq();
    chk("R6 irq after periodic event", {7'b0, irq}, 8'h01);
    idle(2 * PER + 5);
    chk("R8 irq held over later events", {7'b0, irq}, 8'h01);
    rd_reg(8'h0C, v); chk("R6 status flags", v, 8'hC0);
    chk("R7 irq drops after status read", {7'b0, irq}, 8'h00);
    rd_data(v); chk("R8 second status read clear", v, 8'h00);
    access(1'b1, 1'b1, 8'hFF);
    rd_data(v); chk("R10 status write ignored", v, 8'h00);
    chk("R10 irq low after status write", {7'b0, irq}, 8'h00);
    rd_reg(8'h06, v);
    rd_data(v); chk("R11 read data held", v, 8'h00);
  endtask

  task automatic t_interleave();
    wait_irq();
    set_idx(8'h0C);
    set_idx(8'h02);
    rd_data(v); chk("R9 redirected read gave minutes", v, 8'h00);
    chk("R9 irq kept after redirected read", {7'b0, irq}, 8'h01);
    rd_reg(8'h0B, v);
    chk("R9 irq kept after control read", {7'b0, irq}, 8'h01);
    rd_reg(8'h0C, v); chk("R9 proper status read", v, 8'hC0);
    chk("R7 irq rearmed low", {7'b0, irq}, 8'h00);
  endtask

  task automatic t_masked();
    wr_reg(8'h0B, 8'h02);
    rd_reg(8'h0C, v);
    idle(PER + 10);
    chk("R10 irq masked", {7'b0, irq}, 8'h00);
    rd_reg(8'h0C, v); chk("R10 flag set while masked", v, 8'h40);
    rd_reg(8'h0B, v); chk("R10 control readback", v, 8'h02);
    wr_reg(8'h0B, 8'h42);
    rd_reg(8'h0C, v);
  endtask

  initial begin
    n_chk = 0; n_fail = 0; cyc = 0;
    bus_en = 1'b0; bus_wr = 1'b0; bus_port = 1'b0; bus_wdata = 8'h00;
    rst_n = 1'b0;
    idle(3);
    rst_n = 1'b1;
    idle(1);
    t_reset();
    t_index_persist();
    t_seconds();
    t_rollover();
    t_one_shot();
    t_interleave();
    t_masked();
    t_one_shot();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule